// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer Mode

This block stores a small register of single-bit flags. Each bit is reached through a binary address. A serial data bit is written into whichever bit the address selects, and the whole register is always visible on a parallel output bus. Two control inputs choose one of four modes. A write-disable input blocks writes, and a clear input changes meaning according to the write-disable level:

- With writes disabled, the clear input empties the whole register.
- With writes enabled, the clear input turns the block into a one-of-N demultiplexer. The selected output carries the data bit and every other output is forced to zero.

The model is synchronous. The mode inputs, address and data are all sampled on the rising clock edge, and the stored bits change only on that edge. A separate active-low power-on reset clears the register asynchronously. The register width is `2**ADDR_W` bits, eight at the default.

Top module: `addr_latch`

## Requirements
- R1: Address value k (bit 0 of `addrIn` is the least significant) selects stored bit k. That bit appears on `qOut[k]`.
- R2: With `writeDisable`=0 and `clearIn`=0, an edge loads `dataIn` into the addressed bit. Every other bit keeps its value.
- R3: With `writeDisable`=1 and `clearIn`=0, no bit changes at an edge, whatever `addrIn` and `dataIn` are. This includes changes of the address.
- R4: `qOut` always shows all stored bits, whatever the levels of `writeDisable` and `addrIn`.
- R5: With `writeDisable`=1 and `clearIn`=1, an edge clears every bit to 0.
- R6: With `writeDisable`=0 and `clearIn`=1, an edge sets the addressed bit to `dataIn` and every other bit to 0.
- R7: After the block leaves demultiplexer mode, the register keeps the state of the last demultiplexer cycle until the next write or clear.
- R8: `rstN`=0 clears every bit at once, without waiting for a clock edge, whatever `clearIn` is.
- R9: Outputs change only at a rising clock edge. A new input pattern has no effect on `qOut` before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| writeDisable | input | 1 | 1 blocks writes; also selects what `clearIn` does |
| clearIn | input | 1 | Clear-all when writes are disabled; demultiplex when writes are enabled |
| addrIn | input | ADDR_W | Bit address, bit 0 least significant |
| dataIn | input | 1 | Serial data bit |
| qOut | output | 2**ADDR_W | Stored bits, bit k is address k |

## Verification
Four properties are checked on every cycle:

- the hold mode leaves the bus unchanged;
- the clear-all mode empties it;
- a demultiplexer cycle leaves exactly the addressed bit equal to the data;
- a write touches no bit other than the addressed one.

The bench scenarios cover what a single-cycle property cannot show:

- the asynchronous reset acting between edges;
- outputs staying still before the edge;
- the demultiplexer result persisting across later hold cycles;
- a walk of every address.

// File: rtl/addr_latch_pkg.sv
package addr_latch_pkg;
  typedef struct packed {
    logic loadOne;   // write the addressed bit, keep the rest
    logic clearAll;  // empty the register
    logic demux;     // addressed bit = data, others = 0
  } latchStrobe_t;
endpackage

// File: rtl/addr_latch_ctrl.sv
module addr_latch_ctrl
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic                writeDisable,
  input  logic                clearIn,
  input  logic [ADDR_W-1:0]   addrIn,
  output latchStrobe_t        strobe,
  output logic [NUM_BITS-1:0] select
);
  always_comb begin
    strobe          = '0;
    strobe.loadOne  = !writeDisable && !clearIn;
    strobe.clearAll =  writeDisable &&  clearIn;
    strobe.demux    = !writeDisable &&  clearIn;
  end

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_dec
    assign select[i] = (addrIn == ADDR_W'(i));
  end
endmodule

// File: rtl/addr_latch_datapath.sv
module addr_latch_datapath
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  latchStrobe_t        strobe,
  input  logic [NUM_BITS-1:0] select,
  input  logic                dataIn,
  output logic [NUM_BITS-1:0] bits
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_bit
    logic nextBit;
    always_comb begin
      nextBit = bits[i];
      if (strobe.clearAll)                    nextBit = 1'b0;
      else if (strobe.demux)                  nextBit = select[i] & dataIn;
      else if (strobe.loadOne && select[i])   nextBit = dataIn;
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) bits[i] <= 1'b0;
      else       bits[i] <= nextBit;
    end
  end
endmodule

// File: rtl/addr_latch.sv
module addr_latch
  import addr_latch_pkg::*;
#(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                writeDisable,
  input  logic                clearIn,
  input  logic [ADDR_W-1:0]   addrIn,
  input  logic                dataIn,
  output logic [NUM_BITS-1:0] qOut
);
  latchStrobe_t        strobe;
  logic [NUM_BITS-1:0] select;

  addr_latch_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .writeDisable(writeDisable),
    .clearIn     (clearIn),
    .addrIn      (addrIn),
    .strobe      (strobe),
    .select      (select)
  );

  addr_latch_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .select(select),
    .dataIn(dataIn),
    .bits  (qOut)
  );
endmodule

// File: rtl/addr_latch_checker.sv
module addr_latch_checker #(
  parameter int ADDR_W = 3,
  localparam int NUM_BITS = 1 << ADDR_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                writeDisable,
  input logic                clearIn,
  input logic [ADDR_W-1:0]   addrIn,
  input logic                dataIn,
  input logic [NUM_BITS-1:0] qOut
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (writeDisable && !clearIn) |=> (qOut == $past(qOut)));

  p_clear_all_r5: assert property (@(posedge clk) disable iff (!rstN)
    (writeDisable && clearIn) |=> (qOut == '0));

  p_demux_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!writeDisable && clearIn) |=>
      ($countones(qOut) == int'($past(dataIn)) &&
       qOut[$past(addrIn)] == $past(dataIn)));

  p_write_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!writeDisable && !clearIn) |=>
      (qOut[$past(addrIn)] == $past(dataIn) &&
       ((qOut ^ $past(qOut)) & ~(NUM_BITS'(1) << $past(addrIn))) == '0));
endmodule

bind addr_latch addr_latch_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .writeDisable(writeDisable), .clearIn(clearIn),
  .addrIn(addrIn), .dataIn(dataIn), .qOut(qOut)
);

// File: tb/addr_latch_test.sv
module addr_latch_test;
  localparam int ADDR_W = 3;
  localparam int NB = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic writeDisable = 1'b1;
  logic clearIn = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic dataIn = 1'b0;
  logic [NB-1:0] qOut;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  addr_latch #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .writeDisable(writeDisable), .clearIn(clearIn),
    .addrIn(addrIn), .dataIn(dataIn), .qOut(qOut)
  );

  // {req[3:0], writeDisable, clearIn, addr[2:0], data, expected[7:0]}
  localparam int NV = 15;
  localparam logic [17:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 3'd0, 1'b1, 8'h01},  // R2 write bit 0
    {4'd2, 1'b0, 1'b0, 3'd7, 1'b1, 8'h81},  // R2 write bit 7
    {4'd2, 1'b0, 1'b0, 3'd3, 1'b1, 8'h89},  // R2
    {4'd2, 1'b0, 1'b0, 3'd0, 1'b0, 8'h88},  // R2 write zero
    {4'd3, 1'b1, 1'b0, 3'd5, 1'b1, 8'h88},  // R3 hold
    {4'd3, 1'b1, 1'b0, 3'd2, 1'b0, 8'h88},  // R3 hold, new address
    {4'd2, 1'b0, 1'b0, 3'd5, 1'b1, 8'hA8},  // R2
    {4'd6, 1'b0, 1'b1, 3'd2, 1'b1, 8'h04},  // R6 demux
    {4'd6, 1'b0, 1'b1, 3'd6, 1'b0, 8'h00},  // R6 demux data 0
    {4'd6, 1'b0, 1'b1, 3'd6, 1'b1, 8'h40},  // R6
    {4'd7, 1'b1, 1'b0, 3'd1, 1'b1, 8'h40},  // R7 persists
    {4'd7, 1'b0, 1'b0, 3'd1, 1'b1, 8'h42},  // R7 then write
    {4'd2, 1'b0, 1'b0, 3'd4, 1'b1, 8'h52},  // R2
    {4'd5, 1'b1, 1'b1, 3'd4, 1'b1, 8'h00},  // R5 clear all
    {4'd2, 1'b0, 1'b0, 3'd2, 1'b1, 8'h04}   // R2 after clear
  };

  task automatic check(input string req, input logic [NB-1:0] exp);
    checks++;
    if (qOut !== exp) begin
      errors++;
      $display("FAIL %s: qOut=%h expected=%h", req, qOut, exp);
    end
  endtask

  task automatic apply(input logic wd, input logic cl, input logic [ADDR_W-1:0] a, input logic d);
    writeDisable = wd; clearIn = cl; addrIn = a; dataIn = d;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [NB-1:0] snap;
    clearIn = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset state", '0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][13], VEC[i][12], VEC[i][11:9], VEC[i][8]);
      checks++;
      if (qOut !== VEC[i][7:0]) begin
        errors++;
        $display("FAIL R%0d vector %0d: qOut=%h expected=%h",
                 VEC[i][17:14], i, qOut, VEC[i][7:0]);
      end
    end

    // R1: address k drives bit k, walked via demux mode
    for (int k = 0; k < NB; k++) begin
      apply(1'b0, 1'b1, ADDR_W'(k), 1'b1);
      check("R1 address walk", NB'(1) << k);
    end

    // build a pattern, then R4: visible for every address while disabled
    apply(1'b1, 1'b1, 3'd0, 1'b0);
    apply(1'b0, 1'b0, 3'd1, 1'b1);
    apply(1'b0, 1'b0, 3'd6, 1'b1);
    for (int k = 0; k < NB; k++) begin
      apply(1'b1, 1'b0, ADDR_W'(k), k[0]);
      check("R4 readable while disabled", 8'h42);
    end

    // R9: nothing changes before the edge
    snap = qOut;
    writeDisable = 1'b1; clearIn = 1'b1;
    #2;
    check("R9 no change before edge", snap);
    @(negedge clk);
    check("R9 change at edge", '0);

    // R8: asynchronous reset between edges, clearIn low
    apply(1'b0, 1'b0, 3'd3, 1'b1);
    apply(1'b1, 1'b0, 3'd3, 1'b0);
    check("R2 setup for reset", 8'h08);
    #1 rstN = 1'b0;
    #1;
    check("R8 async clear", '0);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 stays clear", '0);

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule